// File: doc/BRIEF.md
# Snooping Write-Back Coherence Controller

This block keeps one small direct-mapped write-back cache coherent with its peers on a shared atomic bus. Every line carries an ownership code: Invalid (no data), Shared (clean, read-only) or Exclusive (the only copy, writable and dirty). Processor reads and writes are served from the line array when the code allows it. Otherwise the controller raises a bus request and, once the bus is granted, places a read miss, a write miss or a write-back of a displaced dirty line on the bus.

At the same time the controller watches the transactions that other caches put on the bus. A hit on a dirty line drives the line's data onto the snoop data output and pulses an abort for one cycle, so that memory drops its own access. A snoop hit can demote the line to Shared or remove it. The line is never changed by a processor access before the grant arrives. The request decision is recomputed every cycle from the current line contents, so a request that waits for the bus restarts from whatever a snoop has left behind.

The address splits into a tag (upper bits) and a line index (lower `IDX_W` bits). A line holds one data word.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req`, `cpu_ready` and `snp_abort` are low, and the first read to each index issues a read miss.
- R2: A read to a line that is not present raises `bus_req` with `bus_cmd` = 0 (read miss) and `bus_addr` = the processor address. In the grant cycle `cpu_ready` is high, `cpu_rdata` equals `bus_rdata`, and the line becomes Shared.
- R3: A write to a line that is Invalid or Shared raises `bus_req` with `bus_cmd` = 1 (write miss) and the processor address. In the grant cycle `cpu_ready` is high and the line becomes Exclusive, holding the written data.
- R4: A read that hits a Shared or Exclusive line, or a write that hits an Exclusive line, completes with `cpu_ready` high in its first cycle and `bus_req` low. A read returns the line data.
- R5: A miss whose index holds an Exclusive line with another tag first issues `bus_cmd` = 2 (write-back), with `bus_addr` = {old tag, index} and `bus_wdata` = the old data. After that grant it issues the read miss or write miss.
- R6: A snooped write miss (`snp_cmd` = 1) to a Shared line makes the line Invalid without asserting `snp_abort`.
- R7: A snooped read miss (`snp_cmd` = 0) to an Exclusive line asserts `snp_abort` for that cycle, with `snp_data` = the line data, and leaves the line Shared.
- R8: A snooped write miss to an Exclusive line asserts `snp_abort` with the line data and leaves the line Invalid.
- R9: In a cycle where a snoop hits, `cpu_ready` and `bus_req` are low. A request that is waiting for the bus is re-decided from the line state that the snoop left.
- R10: A snoop whose tag does not match, or whose line is Invalid, or whose command is a write-back (`snp_cmd` = 2), asserts no abort and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor address: tag in the upper bits, index in the lower bits |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Access completes in this cycle |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_ready` is high |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted; the transaction completes in this cycle |
| bus_cmd | output | 2 | 0 read miss, 1 write miss, 2 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Transaction payload (write-back data or write data) |
| bus_rdata | input | DATA_W | Fill data returned in the grant cycle |
| snp_valid | input | 1 | A transaction from another cache is on the bus |
| snp_cmd | input | 2 | Snooped command, with the same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_abort | output | 1 | This cache supplies the block and memory must abort |
| snp_data | output | DATA_W | Supplied block data while `snp_abort` is high |

## Verification
The properties assume an atomic bus. `bus_gnt` is high only while `bus_req` is high and never in the same cycle as `snp_valid`. The processor inputs stay stable from the request until `cpu_ready`. The bench's bus model grants only a request it has observed, and it issues snoops only between accesses or while a request is still waiting without a grant. That keeps every stimulus inside those assumptions, including the case where a snoop takes the victim line from a waiting miss.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } ln_state_e;

    typedef enum logic [1:0] {
        BC_RDMISS = 2'd0,
        BC_WRMISS = 2'd1,
        BC_WBACK  = 2'd2
    } bus_cmd_e;

    function automatic logic ln_present(ln_state_e s);
        return s != LN_INV;
    endfunction

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
    import coh_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  a_idx,
    output ln_state_e         a_state,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output ln_state_e         b_state,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  ln_state_e         wr_state,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);

    ln_state_e         st_q  [NLINES];
    logic [TAG_W-1:0]  tag_q [NLINES];
    logic [DATA_W-1:0] dat_q [NLINES];

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g]  <= LN_INV;
                tag_q[g] <= '0;
                dat_q[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                st_q[g]  <= wr_state;
                tag_q[g] <= wr_tag;
                dat_q[g] <= wr_data;
            end
        end
    end

    assign a_state = st_q[a_idx];
    assign a_tag   = tag_q[a_idx];
    assign a_data  = dat_q[a_idx];
    assign b_state = st_q[b_idx];
    assign b_tag   = tag_q[b_idx];
    assign b_data  = dat_q[b_idx];

endmodule

// File: rtl/coh_snoop.sv
module coh_snoop
    import coh_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              snp_valid,
    input  bus_cmd_e          snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  ln_state_e         ln_state,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    output logic              hit,
    output logic              abort,
    output logic [DATA_W-1:0] sdata,
    output logic              upd_en,
    output ln_state_e         upd_state
);

    assign hit = snp_valid && ln_present(ln_state) && (ln_tag == snp_tag)
                 && (snp_cmd != BC_WBACK);

    always_comb begin
        abort     = 1'b0;
        upd_en    = 1'b0;
        upd_state = ln_state;
        if (hit) begin
            case (ln_state)
                LN_EXC: begin
                    abort     = 1'b1;
                    upd_en    = 1'b1;
                    upd_state = (snp_cmd == BC_RDMISS) ? LN_SHR : LN_INV;
                end
                LN_SHR: begin
                    if (snp_cmd == BC_WRMISS) begin
                        upd_en    = 1'b1;
                        upd_state = LN_INV;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sdata = abort ? ln_data : '0;

endmodule

// File: rtl/coh_req.sv
module coh_req
    import coh_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8,
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [TAG_W-1:0]  cpu_tag,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  ln_state_e         ln_state,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    input  logic              snoop_hit,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output bus_cmd_e          bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              upd_en,
    output ln_state_e         upd_state,
    output logic [TAG_W-1:0]  upd_tag,
    output logic [DATA_W-1:0] upd_data
);

    logic tag_eq, hit, evict;

    assign tag_eq = (ln_tag == cpu_tag);
    assign hit    = ln_present(ln_state) && tag_eq && (!cpu_we || ln_state == LN_EXC);
    assign evict  = (ln_state == LN_EXC) && !tag_eq;

    always_comb begin
        cpu_ready = 1'b0;
        cpu_rdata = '0;
        bus_req   = 1'b0;
        bus_cmd   = BC_RDMISS;
        bus_addr  = '0;
        bus_wdata = '0;
        upd_en    = 1'b0;
        upd_state = ln_state;
        upd_tag   = ln_tag;
        upd_data  = ln_data;
        if (cpu_req && !snoop_hit) begin
            if (hit) begin
                cpu_ready = 1'b1;
                cpu_rdata = ln_data;
                if (cpu_we) begin
                    upd_en    = 1'b1;
                    upd_state = LN_EXC;
                    upd_data  = cpu_wdata;
                end
            end else if (evict) begin
                bus_req   = 1'b1;
                bus_cmd   = BC_WBACK;
                bus_addr  = {ln_tag, cpu_idx};
                bus_wdata = ln_data;
                if (bus_gnt) begin
                    upd_en    = 1'b1;
                    upd_state = LN_INV;
                end
            end else begin
                bus_req   = 1'b1;
                bus_cmd   = cpu_we ? BC_WRMISS : BC_RDMISS;
                bus_addr  = {cpu_tag, cpu_idx};
                bus_wdata = cpu_we ? cpu_wdata : '0;
                if (bus_gnt) begin
                    cpu_ready = 1'b1;
                    upd_en    = 1'b1;
                    upd_tag   = cpu_tag;
                    if (cpu_we) begin
                        upd_state = LN_EXC;
                        upd_data  = cpu_wdata;
                    end else begin
                        upd_state = LN_SHR;
                        upd_data  = bus_rdata;
                        cpu_rdata = bus_rdata;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8,
    localparam int TAG_W  = ADDR_W - IDX_W,
    localparam int NLINES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_abort,
    output logic [DATA_W-1:0] snp_data
);

    logic [IDX_W-1:0]  cpu_idx, snp_idx;
    logic [TAG_W-1:0]  cpu_tag, snp_tag;
    ln_state_e         a_state, b_state;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DATA_W-1:0] a_data, b_data;

    logic              s_hit, s_upd_en;
    ln_state_e         s_upd_state;
    logic              r_upd_en;
    ln_state_e         r_upd_state;
    logic [TAG_W-1:0]  r_upd_tag;
    logic [DATA_W-1:0] r_upd_data;
    bus_cmd_e          r_cmd;

    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    ln_state_e         wr_state;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

    coh_line_array #(.NLINES(NLINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk(clk), .rst(rst),
        .a_idx(cpu_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
        .b_idx(snp_idx), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_state),
        .wr_tag(wr_tag), .wr_data(wr_data)
    );

    coh_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid(snp_valid), .snp_cmd(bus_cmd_e'(snp_cmd)), .snp_tag(snp_tag),
        .ln_state(b_state), .ln_tag(b_tag), .ln_data(b_data),
        .hit(s_hit), .abort(snp_abort), .sdata(snp_data),
        .upd_en(s_upd_en), .upd_state(s_upd_state)
    );

    coh_req #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_req (
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_tag(cpu_tag), .cpu_idx(cpu_idx),
        .cpu_wdata(cpu_wdata),
        .ln_state(a_state), .ln_tag(a_tag), .ln_data(a_data),
        .snoop_hit(s_hit), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_cmd(r_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .upd_en(r_upd_en), .upd_state(r_upd_state), .upd_tag(r_upd_tag),
        .upd_data(r_upd_data)
    );

    assign bus_cmd = r_cmd;

    // Snooped traffic owns the single write port whenever it changes a line.
    always_comb begin
        if (s_upd_en) begin
            wr_en    = 1'b1;
            wr_idx   = snp_idx;
            wr_state = s_upd_state;
            wr_tag   = b_tag;
            wr_data  = b_data;
        end else begin
            wr_en    = r_upd_en;
            wr_idx   = cpu_idx;
            wr_state = r_upd_state;
            wr_tag   = r_upd_tag;
            wr_data  = r_upd_data;
        end
    end

endmodule

// File: rtl/coh_checker.sv
module coh_checker #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              snp_abort
);

    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> cpu_req); // R2

    AST_HIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && !bus_gnt) |-> !bus_req); // R4

    AST_WB_NOT_REPEATED: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_gnt && bus_cmd == 2'd2)
        |=> !(bus_req && bus_cmd == 2'd2 && bus_addr == $past(bus_addr))); // R5

    AST_ABORT_FROM_SNOOP: assert property (@(posedge clk) disable iff (rst)
        snp_abort |-> (snp_valid && snp_cmd != 2'd2)); // R7

    AST_ABORT_ONCE: assert property (@(posedge clk) disable iff (rst)
        snp_abort |=> !(snp_abort && snp_addr == $past(snp_addr))); // R8

    AST_SNOOP_STALLS_CPU: assert property (@(posedge clk) disable iff (rst)
        snp_abort |-> (!cpu_ready && !bus_req)); // R9

endmodule

bind snoop_cache_ctrl coh_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_snoop_cache_ctrl.sv
module sim_snoop_cache_ctrl;
    localparam int AW = 6;
    localparam int IW = 2;
    localparam int DW = 8;
    localparam int NL = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst;
    logic          cpu_req, cpu_we;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req, bus_gnt;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          snp_valid;
    logic [1:0]    snp_cmd;
    logic [AW-1:0] snp_addr;
    logic          snp_abort;
    logic [DW-1:0] snp_data;

    snoop_cache_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u0 (.*);

    int checks = 0;
    int errors = 0;
    int mem   [64];
    int r_st  [NL];
    int r_tag [NL];
    int r_dat [NL];

    int n_wb, n_miss, wb_addr, wb_data, miss_cmd, miss_addr, got;

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic access(input int we, input int addr, input int wd);
        int guard;
        int cmd, ba, bd;
        bit done;
        n_wb = 0; n_miss = 0; got = -1; done = 0; guard = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we[0]; cpu_addr = AW'(addr); cpu_wdata = DW'(wd);
        while (!done && guard < 20) begin
            guard++;
            #1;
            if (cpu_ready) begin
                got = int'(cpu_rdata);
                done = 1;
                @(negedge clk);
            end else if (bus_req) begin
                cmd = int'(bus_cmd); ba = int'(bus_addr); bd = int'(bus_wdata);
                bus_gnt = 1'b1;
                bus_rdata = DW'(mem[ba]);
                #1;
                if (cmd == 2) begin n_wb++; wb_addr = ba; wb_data = bd; end
                else begin n_miss++; miss_cmd = cmd; miss_addr = ba; end
                if (cpu_ready) begin got = int'(cpu_rdata); done = 1; end
                @(negedge clk);
                if (cmd == 2) mem[ba] = bd;
                bus_gnt = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        if (!done) chk("R2 access completes", 0, 1);
        cpu_req = 1'b0;
    endtask

    task automatic run_access(input int we, input int addr, input int wd);
        int idx, tg, e_wb, e_wba, e_wbd, e_rd;
        bit hit;
        string rq;
        idx = addr % NL; tg = addr / NL;
        hit = (r_st[idx] != 0) && (r_tag[idx] == tg) && (we == 0 || r_st[idx] == 2);
        e_wb = 0; e_wba = 0; e_wbd = 0; e_rd = 0;
        if (hit) begin
            e_rd = r_dat[idx];
            if (we != 0) r_dat[idx] = wd & 255;
            rq = "R4";
        end else begin
            if (r_st[idx] == 2) begin
                e_wb = 1; e_wba = r_tag[idx] * NL + idx; e_wbd = r_dat[idx];
            end
            e_rd = mem[addr];
            r_st[idx]  = (we != 0) ? 2 : 1;
            r_tag[idx] = tg;
            r_dat[idx] = (we != 0) ? (wd & 255) : e_rd;
            rq = e_wb != 0 ? "R5" : (we != 0 ? "R3" : "R2");
        end
        access(we, addr, wd);
        chk(rq, n_wb, e_wb);
        chk(rq, n_miss, hit ? 0 : 1);
        if (e_wb != 0) begin chk(rq, wb_addr, e_wba); chk(rq, wb_data, e_wbd); end
        if (!hit) begin chk(rq, miss_cmd, we != 0 ? 1 : 0); chk(rq, miss_addr, addr); end
        if (we == 0) chk(rq, got, e_rd);
    endtask

    task automatic run_snoop(input int cmd, input int addr);
        int idx, tg, ab, sd, old;
        bit hit;
        string rq;
        idx = addr % NL; tg = addr / NL; old = r_st[idx];
        hit = (old != 0) && (r_tag[idx] == tg) && (cmd != 2);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_addr = AW'(addr);
        #1;
        ab = int'(snp_abort); sd = int'(snp_data);
        @(negedge clk);
        snp_valid = 1'b0;
        if (!hit) rq = "R10";
        else if (old == 2) rq = (cmd == 0) ? "R7" : "R8";
        else rq = "R6";
        chk(rq, ab, (hit && old == 2) ? 1 : 0);
        if (hit && old == 2) begin
            chk(rq, sd, r_dat[idx]);
            mem[addr] = r_dat[idx];
            r_st[idx] = (cmd == 0) ? 1 : 0;
        end else if (hit && cmd == 1) begin
            r_st[idx] = 0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int misses;
        for (int a = 0; a < 64; a++) mem[a] = (a * 3 + 1) & 255;
        for (int i = 0; i < NL; i++) begin r_st[i] = 0; r_tag[i] = 0; r_dat[i] = 0; end
        rst = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        bus_gnt = 1'b0; bus_rdata = '0; snp_valid = 1'b0; snp_cmd = '0; snp_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 bus_req", int'(bus_req), 0);
        chk("R1 cpu_ready", int'(cpu_ready), 0);
        chk("R1 snp_abort", int'(snp_abort), 0);

        misses = 0;
        for (int i = 0; i < NL; i++) begin
            run_access(0, i, 0);
            misses += n_miss;
        end
        chk("R1 first reads miss", misses, NL);

        // R6: shared copy dropped by a snooped write miss
        run_access(0, 5, 0);
        run_snoop(1, 5);
        run_access(0, 5, 0);
        chk("R6 refetch after invalidate", n_miss, 1);

        // R7: dirty line supplied on a snooped read, demoted to Shared
        run_access(1, 9, 8'hA5);
        run_snoop(0, 9);
        run_access(0, 9, 0);
        chk("R7 read hits after demotion", n_miss, 0);
        run_access(1, 9, 8'h5A);
        chk("R7 write needs write miss", n_miss, 1);

        // R8: dirty line supplied on a snooped write, removed
        run_access(1, 13, 8'h77);
        run_snoop(1, 13);
        run_access(0, 13, 0);
        chk("R8 refetch after removal", n_miss, 1);

        // R9: snoop takes the victim of a waiting miss
        run_access(1, 2, 8'h3C);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(6);
        #1;
        chk("R9 waiting write-back req", int'(bus_req), 1);
        chk("R9 waiting write-back cmd", int'(bus_cmd), 2);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 2'd0; snp_addr = AW'(2);
        #1;
        chk("R9 stall ready", int'(cpu_ready), 0);
        chk("R9 stall bus_req", int'(bus_req), 0);
        chk("R9 abort", int'(snp_abort), 1);
        chk("R9 data", int'(snp_data), 8'h3C);
        mem[2] = 8'h3C;
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk("R9 restart req", int'(bus_req), 1);
        chk("R9 restart as read miss", int'(bus_cmd), 0);
        bus_gnt = 1'b1; bus_rdata = DW'(mem[6]);
        #1;
        chk("R9 completes", int'(cpu_ready), 1);
        chk("R9 rdata", int'(cpu_rdata), mem[6]);
        @(negedge clk);
        bus_gnt = 1'b0; cpu_req = 1'b0;
        r_st[2] = 1; r_tag[2] = 1; r_dat[2] = mem[6];

        // Near-exhaustive mixed sweep against the reference model
        for (int i = 0; i < 400; i++) begin
            if (i % 4 == 3) run_snoop(i % 3, (i * 11 + 1) % 64);
            else run_access(((i % 3) == 0) ? 1 : 0, (i * 7 + 3) % 64, (i * 29 + 7) & 255);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule